// File: doc/BRIEF.md
# Blanked Fault Qualifier with Strike Counters

This block sits between two raw analog comparator flags of a battery charging path and the switch sequencer that drives the pass transistor. One flag reports overcurrent and the other reports battery overvoltage. Each flag has its own blanking window. A flag counts as a real fault only if it stays high for every clock of that window, so short transients are filtered out.

Each qualified fault does two things. It raises a one-cycle turn-off request to the sequencer, and it advances a 4-bit strike counter that belongs to that fault type. The sixteenth strike of either type makes the block raise a sticky latch-off output. This output keeps the switch off for good. Only a rearm pulse clears it, and that pulse comes from a power recycle or from toggling the enable.

After a strike, the fault type that struck is disarmed. It is armed again only once its flag has fallen and the sequencer reports that the restart has finished. A flag that stays high therefore counts as exactly one strike.

Top module: `fault_strike_guard`

## Requirements
- R1: While `rstN` is low, and right after it rises, `ocCount` and `bovCount` read 0, and `tripReq` and `latchOff` read 0.
- R2: Suppose `ocRaw` is high on OC_BLANK consecutive rising edges while the overcurrent channel is armed. Then on the last of those edges `ocCount` goes up by 1, and `tripReq` is high for the following cycle.
- R3: The battery-overvoltage channel follows the same rule as R2, using `bovRaw`, BOV_BLANK and `bovCount`.
- R4: A flag that drops before its window completes gives no `tripReq` and no count. A later attempt must again hold the flag high for a full window, counted from zero.
- R5: After a strike, a channel re-arms only on a rising edge where its flag is low and `restartDone` is high. Until that happens, its flag has no effect.
- R6: The two counters are independent. A strike on one channel never changes the other channel's count, and neither counter ever wraps.
- R7: If both channels qualify on the same edge, both counters go up by 1 and `tripReq` is high for exactly one cycle.
- R8: A strike that arrives while its counter already holds 15 sets `latchOff` together with a `tripReq` pulse, and that counter stays at 15.
- R9: While `latchOff` is high, both flags and `restartDone` have no effect: the counts hold and `tripReq` stays low.
- R10: `rearmPulse` high at a rising edge clears both counts and `latchOff`, restarts both blanking windows from zero, and re-arms both channels. It takes priority over a strike that qualifies on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ocRaw | input | 1 | Raw overcurrent comparator flag |
| bovRaw | input | 1 | Raw battery-overvoltage comparator flag |
| rearmPulse | input | 1 | Power-recycle or enable-toggle pulse; clears counts and latch |
| restartDone | input | 1 | The sequencer has finished restarting the switch |
| tripReq | output | 1 | One-cycle turn-off request for each qualified strike |
| latchOff | output | 1 | Sticky permanent-off request |
| ocCount | output | CNT_W | Overcurrent strike count |
| bovCount | output | CNT_W | Battery-overvoltage strike count |

## Verification
The hardest case to reach is two strikes of different types qualifying on the same clock edge, because the two windows have different lengths. The stimulus raises the overvoltage flag BOV_BLANK minus OC_BLANK cycles ahead of the overcurrent flag, so that both windows close on the same edge.

Reaching the latch also takes some setup. It needs fifteen full arm, strike and re-arm rounds on one channel before the sixteenth strike. The test then pairs a rearm pulse with an edge on which a strike would have qualified.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_OC  = 0;
  localparam int CH_BOV = 1;

  typedef struct packed {
    logic              clrAll;
    logic [NUM_CH-1:0] run;
    logic [NUM_CH-1:0] inc;
  } fsg_strobe_t;
endpackage

// File: rtl/fsg_chan.sv
module fsg_chan #(
  parameter int BLANK = 34000,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flag,
  input  logic             run,
  input  logic             inc,
  input  logic             clr,
  output logic             qual,
  output logic             sat,
  output logic [CNT_W-1:0] cnt
);
  localparam int TW = $clog2(BLANK + 1);
  localparam logic [TW-1:0] LAST = TW'(BLANK - 1);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [TW-1:0] timer;

  assign qual = flag & run & (timer == LAST);
  assign sat  = (cnt == MAXC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (clr || !flag || !run || qual) begin
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && !sat) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: count moves by at most one step
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  // R8: a saturated counter holds
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sat && !clr) |=> sat);
  // R4: a count only follows a high flag
  p_cnt_needs_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != $past(cnt) && !$past(clr)) |-> $past(flag));
endmodule

// File: rtl/fsg_dp.sv
module fsg_dp
  import fsg_pkg::*;
#(
  parameter int OC_BLANK  = 34000,
  parameter int BOV_BLANK = 36000,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] flags,
  input  fsg_strobe_t       stb,
  output logic [NUM_CH-1:0] qual,
  output logic [NUM_CH-1:0] sat,
  output logic [CNT_W-1:0]  ocCount,
  output logic [CNT_W-1:0]  bovCount
);
  logic [CNT_W-1:0] cntArr [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BL = (i == CH_OC) ? OC_BLANK : BOV_BLANK;
    fsg_chan #(.BLANK(BL), .CNT_W(CNT_W)) u_chan (
      .clk  (clk),
      .rstN (rstN),
      .flag (flags[i]),
      .run  (stb.run[i]),
      .inc  (stb.inc[i]),
      .clr  (stb.clrAll),
      .qual (qual[i]),
      .sat  (sat[i]),
      .cnt  (cntArr[i])
    );
  end

  assign ocCount  = cntArr[CH_OC];
  assign bovCount = cntArr[CH_BOV];
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] flags,
  input  logic              rearmPulse,
  input  logic              restartDone,
  input  logic [NUM_CH-1:0] qual,
  input  logic [NUM_CH-1:0] sat,
  output fsg_strobe_t       stb,
  output logic              tripReq,
  output logic              latchOff
);
  logic [NUM_CH-1:0] armed;

  always_comb begin
    stb.clrAll = rearmPulse;
    stb.run    = armed & {NUM_CH{~latchOff}};
    stb.inc    = qual & {NUM_CH{~rearmPulse}};
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_arm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed[i] <= 1'b1;
      end else if (rearmPulse) begin
        armed[i] <= 1'b1;
      end else if (stb.inc[i]) begin
        armed[i] <= 1'b0;
      end else if (!flags[i] && restartDone) begin
        armed[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripReq  <= 1'b0;
      latchOff <= 1'b0;
    end else if (rearmPulse) begin
      tripReq  <= 1'b0;
      latchOff <= 1'b0;
    end else begin
      tripReq <= |stb.inc;
      if (|(stb.inc & sat)) latchOff <= 1'b1;
    end
  end

  // R9: latch is sticky until rearm
  p_latch_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (latchOff && !rearmPulse) |=> latchOff);
  // R9: no turn-off requests once latched
  p_no_trip_latched_r9: assert property (@(posedge clk) disable iff (!rstN)
    (latchOff && !rearmPulse) |=> !tripReq);
  // R8: latch rises together with a turn-off request
  p_latch_with_trip_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchOff) |-> tripReq);
endmodule

// File: rtl/fault_strike_guard.sv
module fault_strike_guard
  import fsg_pkg::*;
#(
  parameter int OC_BLANK  = 34000,
  parameter int BOV_BLANK = 36000,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ocRaw,
  input  logic             bovRaw,
  input  logic             rearmPulse,
  input  logic             restartDone,
  output logic             tripReq,
  output logic             latchOff,
  output logic [CNT_W-1:0] ocCount,
  output logic [CNT_W-1:0] bovCount
);
  fsg_strobe_t       stb;
  logic [NUM_CH-1:0] qual;
  logic [NUM_CH-1:0] sat;
  logic [NUM_CH-1:0] flags;

  assign flags = {bovRaw, ocRaw};

  fsg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flags       (flags),
    .rearmPulse  (rearmPulse),
    .restartDone (restartDone),
    .qual        (qual),
    .sat         (sat),
    .stb         (stb),
    .tripReq     (tripReq),
    .latchOff    (latchOff)
  );

  fsg_dp #(.OC_BLANK(OC_BLANK), .BOV_BLANK(BOV_BLANK), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .flags    (flags),
    .stb      (stb),
    .qual     (qual),
    .sat      (sat),
    .ocCount  (ocCount),
    .bovCount (bovCount)
  );

  // R10: rearm clears everything on the next edge
  p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    rearmPulse |=> (ocCount == '0 && bovCount == '0 && !latchOff && !tripReq));
endmodule

// File: tb/sim_fault_strike_guard.sv
`timescale 1ns/1ps
module sim_fault_strike_guard;
  localparam int OCB = 5;
  localparam int BVB = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ocRaw = 1'b0, bovRaw = 1'b0, rearmPulse = 1'b0, restartDone = 1'b0;
  logic tripReq, latchOff;
  logic [3:0] ocCount, bovCount;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  fault_strike_guard #(.OC_BLANK(OCB), .BOV_BLANK(BVB), .CNT_W(4)) u0 (
    .clk(clk), .rstN(rstN), .ocRaw(ocRaw), .bovRaw(bovRaw),
    .rearmPulse(rearmPulse), .restartDone(restartDone),
    .tripReq(tripReq), .latchOff(latchOff),
    .ocCount(ocCount), .bovCount(bovCount)
  );

  // behavioural reference
  int mRun[2], mCnt[2];
  bit mArmed[2];
  bit mLatch, mTrip;

  always @(posedge clk or negedge rstN) begin
    if (!rstN || rearmPulse) begin
      for (int i = 0; i < 2; i++) begin mRun[i] = 0; mCnt[i] = 0; mArmed[i] = 1; end
      mLatch = 0; mTrip = 0;
    end else begin
      bit anyQ, newLatch;
      anyQ = 0; newLatch = 0;
      for (int i = 0; i < 2; i++) begin
        bit fl;
        int bl;
        fl = (i == 0) ? ocRaw : bovRaw;
        bl = (i == 0) ? OCB : BVB;
        if (!mLatch && mArmed[i] && fl && (mRun[i] + 1 >= bl)) begin
          anyQ = 1; mArmed[i] = 0; mRun[i] = 0;
          if (mCnt[i] == 15) newLatch = 1; else mCnt[i]++;
        end else if (!fl) begin
          mRun[i] = 0;
          if (restartDone) mArmed[i] = 1;
        end else if (mArmed[i] && !mLatch) mRun[i]++;
        else mRun[i] = 0;
      end
      if (newLatch) mLatch = 1;
      mTrip = anyQ;
    end
  end

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " model ocCount"}, ocCount, mCnt[0]);
      check({curReq, " model bovCount"}, bovCount, mCnt[1]);
      check({curReq, " model tripReq"}, tripReq, mTrip);
      check({curReq, " model latchOff"}, latchOff, mLatch);
    end
  end

  task automatic drive(bit o, bit b, bit rd, bit rp, int n);
    ocRaw = o; bovRaw = b; restartDone = rd; rearmPulse = rp;
    repeat (n) @(negedge clk);
  endtask

  task automatic ocEvent();
    drive(1, 0, 0, 0, OCB);
    drive(0, 0, 1, 0, 1);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #50000;
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ocCount", ocCount, 0);
    check("R1 reset latchOff", latchOff, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset bovCount", bovCount, 0);
    check("R1 after reset tripReq", tripReq, 0);

    curReq = "R2";
    drive(1, 0, 0, 0, OCB);
    check("R2 trip on window end", tripReq, 1);
    check("R2 ocCount", ocCount, 1);
    drive(0, 0, 1, 0, 1);
    check("R2 trip one cycle", tripReq, 0);

    curReq = "R4";
    drive(1, 0, 0, 0, OCB - 1);
    drive(0, 0, 1, 0, 1);
    check("R4 short flag not counted", ocCount, 1);
    drive(1, 0, 0, 0, OCB - 1);
    drive(0, 0, 0, 0, 1);
    drive(1, 0, 0, 0, OCB - 1);
    drive(0, 0, 1, 0, 1);
    check("R4 split flag not counted", ocCount, 1);

    curReq = "R3";
    drive(0, 1, 0, 0, BVB);
    check("R3 bov trip", tripReq, 1);
    check("R3 bovCount", bovCount, 1);
    drive(0, 0, 1, 0, 1);

    curReq = "R5";
    drive(1, 0, 0, 0, 3 * OCB);
    check("R5 long flag counts once", ocCount, 2);
    drive(0, 0, 0, 0, 3);
    drive(1, 0, 0, 0, 2 * OCB);
    check("R5 no rearm without restartDone", ocCount, 2);
    drive(0, 0, 1, 0, 1);
    drive(1, 0, 0, 0, OCB);
    check("R5 counts after rearm", ocCount, 3);
    drive(0, 0, 1, 0, 1);

    curReq = "R7";
    drive(0, 1, 0, 0, BVB - OCB);
    drive(1, 1, 0, 0, OCB);
    check("R7 joint trip", tripReq, 1);
    check("R7 ocCount", ocCount, 4);
    check("R7 bovCount", bovCount, 2);
    drive(0, 0, 1, 0, 1);
    check("R7 single trip cycle", tripReq, 0);

    curReq = "R8";
    for (int k = 0; k < 11; k++) ocEvent();
    check("R8 count at 15", ocCount, 15);
    check("R8 not yet latched", latchOff, 0);
    drive(1, 0, 0, 0, OCB);
    check("R8 latch on 16th", latchOff, 1);
    check("R8 trip on 16th", tripReq, 1);
    check("R8 count holds", ocCount, 15);
    check("R6 other counter untouched", bovCount, 2);
    drive(0, 0, 1, 0, 1);

    curReq = "R9";
    drive(1, 1, 1, 0, 3 * BVB);
    check("R9 latched trip", tripReq, 0);
    check("R9 latched ocCount", ocCount, 15);
    check("R9 latched bovCount", bovCount, 2);
    check("R9 latch held", latchOff, 1);

    curReq = "R10";
    drive(0, 0, 0, 1, 1);
    check("R10 latch cleared", latchOff, 0);
    check("R10 ocCount cleared", ocCount, 0);
    check("R10 bovCount cleared", bovCount, 0);
    drive(1, 0, 0, 0, OCB - 1);
    drive(1, 0, 0, 1, 1);
    check("R10 rearm beats strike", ocCount, 0);
    check("R10 no trip on rearm", tripReq, 0);
    drive(1, 0, 0, 0, OCB);
    check("R10 window restarted", ocCount, 1);
    drive(0, 0, 1, 0, 2);

    finishRun();
  end
endmodule